// File: doc/BRIEF.md
# Dual-Channel Serial ADC Frame Controller

This block is the host-side controller for a 16-bit successive-approximation converter that has a two-input multiplexer and a full-duplex serial port. On a start request it raises the conversion strobe and holds it for a programmable number of system clocks. It then lowers the strobe and produces 16 shift-clock periods from the system clock at a programmable half-period. During those periods it sends a 2-bit multiplexer word and collects the 16-bit result, most significant bit first.

The converter applies the multiplexer word it receives in a frame to the *next* conversion. The controller therefore keeps the word it sent in the previous frame and attaches it to each result as a tag. The first result after reset has no known configuration, so it carries an "unknown" flag. If a start request arrives while a frame is running, it is held and then served as soon as the current frame ends.

Top module: `adcq_ctrl`

## Requirements
- R1: After an accepted start, `adc_conv_o` rises and stays high for exactly max(`conv_wait_i`,1) system clocks. The value of `conv_wait_i` is latched when the start is accepted, so later changes to it during the frame have no effect.
- R2: A frame has exactly 16 rising edges of `adc_sck_o`. Each high phase lasts max(`sck_half_i`,1) system clocks, with the half-period latched at start. `adc_sck_o` is low whenever it is idle and whenever `adc_conv_o` is high.
- R3: `res_data_o` holds the 16 values of `adc_sdo_i` sampled on the rising edges of `adc_sck_o`. The first sample lands in bit 15 and the last in bit 0.
- R4: In each frame, `adc_sdi_o` carries `cfg_i[1]` (single-ended select) before the first rising edge of `adc_sck_o` and `cfg_i[0]` (odd/sign) before the second. It is 0 for every later bit. It changes only while `adc_sck_o` is low.
- R5: `res_cfg_o` is the configuration word sent in the previous frame, with `res_cfg_unknown_o`=0. The first result after reset has `res_cfg_unknown_o`=1.
- R6: `res_valid_o` is high for exactly one clock per completed frame.
- R7: A start request made while a frame is running is served after that frame. Several requests made while busy produce only one extra frame, and that frame uses the configuration of the last request.
- R8: During and after reset, `adc_conv_o`, `adc_sck_o`, `adc_sdi_o`, `res_valid_o` and `busy_o` are all 0.
- R9: `busy_o` is high from the clock after a start is accepted until the last frame, including any pending one, has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Frame request strobe |
| cfg_i | input | 2 | {single-ended, odd/sign} multiplexer word for the request |
| conv_wait_i | input | 16 | Conversion-strobe high time in clocks (0 treated as 1) |
| sck_half_i | input | 8 | Shift-clock half-period in clocks (0 treated as 1) |
| adc_conv_o | output | 1 | Conversion strobe to the converter |
| adc_sck_o | output | 1 | Shift clock to the converter |
| adc_sdi_o | output | 1 | Serial data to the converter |
| adc_sdo_i | input | 1 | Serial data from the converter |
| busy_o | output | 1 | Frame running or pending |
| res_data_o | output | 16 | Captured conversion result |
| res_cfg_o | output | 2 | Multiplexer word that produced the result |
| res_cfg_unknown_o | output | 1 | Result configuration unknown (first frame) |
| res_valid_o | output | 1 | One-clock result strobe |

## Verification
The assertions check, on every clock, the properties that hold at every moment. The shift clock stays low while the strobe is high, the serial data changes only during low shift-clock phases, the tail bits are zero, the valid pulse lasts one clock, a queued request launches immediately from idle, and the first result is flagged unknown. The bench scenarios cover everything that depends on counting over a whole frame or on history across frames. This includes the exact number of shift-clock edges, the strobe and half-period lengths under random settings, input latching, the bit order of results, the one-frame lag of the configuration tag, and merging of queued requests. A converter model in the bench checks these from the port side.

// File: rtl/adcq_pkg.sv
package adcq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CONV,
    ST_SHIFT,
    ST_REST
  } seq_st_e;

  typedef struct packed {
    logic single;
    logic odd;
  } mux_cfg_t;
endpackage

// File: rtl/adcq_sck_gen.sv
module adcq_sck_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic [DIV_W-1:0] half_i,
  output logic             sck_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             sck_q;
  logic             wrap;

  assign wrap   = run_i && (cnt_q == half_i - 1'b1);
  assign rise_o = wrap && !sck_q;
  assign fall_o = wrap && sck_q;
  assign sck_o  = sck_q;

  always_ff @(posedge clk) begin
    if (rst || !run_i) begin
      cnt_q <= '0;
      sck_q <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      sck_q <= ~sck_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R2
  sck_idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> !sck_q);
endmodule

// File: rtl/adcq_shifter.sv
module adcq_shifter
  import adcq_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  mux_cfg_t          cfg_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              sdo_i,
  output logic              sdi_o,
  output logic [DATA_W-1:0] word_o
);
  localparam int PAD_W = DATA_W - $bits(mux_cfg_t);

  logic [DATA_W-1:0] tx_q;
  logic [DATA_W-1:0] rx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_q <= '0;
      rx_q <= '0;
    end else if (load_i) begin
      tx_q <= {cfg_i, {PAD_W{1'b0}}};
      rx_q <= '0;
    end else begin
      if (fall_i) tx_q <= {tx_q[DATA_W-2:0], 1'b0};
      if (rise_i) rx_q <= {rx_q[DATA_W-2:0], sdo_i};
    end
  end

  assign sdi_o  = tx_q[DATA_W-1];
  assign word_o = rx_q;

  // R3
  rx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!rise_i && !load_i) |=> $stable(rx_q));
endmodule

// File: rtl/adcq_seq.sv
module adcq_seq
  import adcq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DIV_W  = 8,
  parameter int WAIT_W = 16,
  localparam int CNT_W = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  mux_cfg_t          cfg_i,
  input  logic [WAIT_W-1:0] wait_i,
  input  logic [DIV_W-1:0]  half_i,
  input  logic              fall_i,
  input  logic [DATA_W-1:0] word_i,
  output logic              conv_o,
  output logic              run_o,
  output logic              load_o,
  output logic [DIV_W-1:0]  half_o,
  output mux_cfg_t          cur_cfg_o,
  output logic [CNT_W-1:0]  bit_idx_o,
  output logic              busy_o,
  output logic [DATA_W-1:0] res_data_o,
  output mux_cfg_t          res_cfg_o,
  output logic              res_unk_o,
  output logic              res_valid_o
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  seq_st_e           st_q;
  logic              pend_q;
  mux_cfg_t          pend_cfg_q;
  mux_cfg_t          cur_cfg_q;
  mux_cfg_t          prev_cfg_q;
  logic              prev_ok_q;
  logic [WAIT_W-1:0] wlat_q;
  logic [WAIT_W-1:0] wcnt_q;
  logic [DIV_W-1:0]  hlat_q;
  logic [CNT_W-1:0]  fcnt_q;
  logic              conv_q;

  logic     launch;
  mux_cfg_t launch_cfg;
  logic     conv_done;

  assign launch     = (st_q == ST_IDLE) && (pend_q || start_i);
  assign launch_cfg = pend_q ? pend_cfg_q : cfg_i;
  assign conv_done  = (st_q == ST_CONV) && (wcnt_q >= wlat_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_IDLE;
      pend_q      <= 1'b0;
      pend_cfg_q  <= '0;
      cur_cfg_q   <= '0;
      prev_cfg_q  <= '0;
      prev_ok_q   <= 1'b0;
      wlat_q      <= WAIT_W'(1);
      wcnt_q      <= '0;
      hlat_q      <= DIV_W'(1);
      fcnt_q      <= '0;
      conv_q      <= 1'b0;
      res_data_o  <= '0;
      res_cfg_o   <= '0;
      res_unk_o   <= 1'b0;
      res_valid_o <= 1'b0;
    end else begin
      res_valid_o <= 1'b0;

      // request queue: one pending slot, newest configuration wins
      if (st_q == ST_IDLE) begin
        if (pend_q) begin
          pend_q <= start_i;
          if (start_i) pend_cfg_q <= cfg_i;
        end
      end else if (start_i) begin
        pend_q     <= 1'b1;
        pend_cfg_q <= cfg_i;
      end

      unique case (st_q)
        ST_IDLE: begin
          if (launch) begin
            st_q      <= ST_CONV;
            conv_q    <= 1'b1;
            wcnt_q    <= WAIT_W'(1);
            cur_cfg_q <= launch_cfg;
            wlat_q    <= (wait_i == '0) ? WAIT_W'(1) : wait_i;
            hlat_q    <= (half_i == '0) ? DIV_W'(1) : half_i;
          end
        end
        ST_CONV: begin
          if (conv_done) begin
            st_q   <= ST_SHIFT;
            conv_q <= 1'b0;
            fcnt_q <= '0;
          end else begin
            wcnt_q <= wcnt_q + 1'b1;
          end
        end
        ST_SHIFT: begin
          if (fall_i) begin
            if (fcnt_q == LAST_BIT) begin
              st_q        <= ST_REST;
              res_data_o  <= word_i;
              res_cfg_o   <= prev_cfg_q;
              res_unk_o   <= !prev_ok_q;
              res_valid_o <= 1'b1;
              prev_cfg_q  <= cur_cfg_q;
              prev_ok_q   <= 1'b1;
            end else begin
              fcnt_q <= fcnt_q + 1'b1;
            end
          end
        end
        ST_REST: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign conv_o    = conv_q;
  assign run_o     = (st_q == ST_SHIFT);
  assign load_o    = conv_done;
  assign half_o    = hlat_q;
  assign cur_cfg_o = cur_cfg_q;
  assign bit_idx_o = fcnt_q;
  assign busy_o    = (st_q != ST_IDLE) || pend_q;

  // R6
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid_o |=> !res_valid_o);

  // R7
  pend_launch_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE && pend_q) |=> (st_q == ST_CONV && conv_q));

  // R5
  first_tag_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(prev_ok_q) |-> (res_valid_o && res_unk_o));

  // R1
  conv_min_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(conv_q) |=> (st_q == ST_CONV || st_q == ST_SHIFT));
endmodule

// File: rtl/adcq_ctrl.sv
module adcq_ctrl
  import adcq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DIV_W  = 8,
  parameter int WAIT_W = 16,
  localparam int CFG_W = $bits(mux_cfg_t),
  localparam int CNT_W = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [CFG_W-1:0]  cfg_i,
  input  logic [WAIT_W-1:0] conv_wait_i,
  input  logic [DIV_W-1:0]  sck_half_i,
  output logic              adc_conv_o,
  output logic              adc_sck_o,
  output logic              adc_sdi_o,
  input  logic              adc_sdo_i,
  output logic              busy_o,
  output logic [DATA_W-1:0] res_data_o,
  output logic [CFG_W-1:0]  res_cfg_o,
  output logic              res_cfg_unknown_o,
  output logic              res_valid_o
);
  logic              run;
  logic              load;
  logic              rise;
  logic              fall;
  logic [DIV_W-1:0]  half_lat;
  mux_cfg_t          cur_cfg;
  mux_cfg_t          res_cfg;
  logic [CNT_W-1:0]  bit_idx;
  logic [DATA_W-1:0] word;

  adcq_seq #(
    .DATA_W(DATA_W),
    .DIV_W (DIV_W),
    .WAIT_W(WAIT_W)
  ) seq_i (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .cfg_i      (mux_cfg_t'(cfg_i)),
    .wait_i     (conv_wait_i),
    .half_i     (sck_half_i),
    .fall_i     (fall),
    .word_i     (word),
    .conv_o     (adc_conv_o),
    .run_o      (run),
    .load_o     (load),
    .half_o     (half_lat),
    .cur_cfg_o  (cur_cfg),
    .bit_idx_o  (bit_idx),
    .busy_o     (busy_o),
    .res_data_o (res_data_o),
    .res_cfg_o  (res_cfg),
    .res_unk_o  (res_cfg_unknown_o),
    .res_valid_o(res_valid_o)
  );

  adcq_sck_gen #(
    .DIV_W(DIV_W)
  ) sck_i (
    .clk   (clk),
    .rst   (rst),
    .run_i (run),
    .half_i(half_lat),
    .sck_o (adc_sck_o),
    .rise_o(rise),
    .fall_o(fall)
  );

  adcq_shifter #(
    .DATA_W(DATA_W)
  ) shf_i (
    .clk   (clk),
    .rst   (rst),
    .load_i(load),
    .cfg_i (cur_cfg),
    .rise_i(rise),
    .fall_i(fall),
    .sdo_i (adc_sdo_i),
    .sdi_o (adc_sdi_o),
    .word_o(word)
  );

  assign res_cfg_o = res_cfg;

  // R2
  conv_sck_excl_chk: assert property (@(posedge clk) disable iff (rst)
    adc_conv_o |-> !adc_sck_o);

  // R4
  sdi_low_phase_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(adc_sdi_o) |-> !adc_sck_o);

  // R4
  sdi_tail_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (run && bit_idx >= CNT_W'(2)) |-> !adc_sdi_o);

  // R2
  conv_then_shift_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(adc_conv_o) |-> (run && !adc_sck_o));
endmodule

// File: tb/adcq_ctrl_tb_top.sv
module adcq_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int VW = 8;
  localparam int WW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_i = 1'b0;
  logic [1:0]    cfg_i = '0;
  logic [WW-1:0] conv_wait_i = '0;
  logic [VW-1:0] sck_half_i = '0;
  logic          adc_conv_o, adc_sck_o, adc_sdi_o, adc_sdo;
  logic          busy_o, res_cfg_unknown_o, res_valid_o;
  logic [DW-1:0] res_data_o;
  logic [1:0]    res_cfg_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  adcq_ctrl #(.DATA_W(DW), .DIV_W(VW), .WAIT_W(WW)) dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .cfg_i(cfg_i),
    .conv_wait_i(conv_wait_i), .sck_half_i(sck_half_i),
    .adc_conv_o(adc_conv_o), .adc_sck_o(adc_sck_o), .adc_sdi_o(adc_sdi_o),
    .adc_sdo_i(adc_sdo), .busy_o(busy_o), .res_data_o(res_data_o),
    .res_cfg_o(res_cfg_o), .res_cfg_unknown_o(res_cfg_unknown_o),
    .res_valid_o(res_valid_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] word_fn(input int n);
    case (n)
      0: return 16'hA5C3;
      1: return 16'h0000;
      2: return 16'hFFFF;
      3: return 16'h8001;
      4: return 16'h0001;
      default: return DW'((n * 40503) ^ 16'h5A5A);
    endcase
  endfunction

  // expected per-frame configuration, in frame order
  logic [1:0] exp_cfg [64];
  int n_exp = 0;
  int exp_wait = 1;
  int exp_half = 1;

  // converter model
  logic [DW-1:0] dev_sr = '0;
  int dev_frame = 0;
  int dev_idx = 0;
  int dev_rises = 0;
  int tail_bad = 0;
  logic dev_c1 = 1'b0;

  assign adc_sdo = dev_sr[DW-1];

  always @(negedge adc_conv_o) begin
    if (!rst) begin
      dev_sr = word_fn(dev_frame);
      dev_idx = dev_frame;
      dev_frame++;
      dev_rises = 0;
      tail_bad = 0;
    end
  end

  always @(negedge adc_sck_o) begin
    if (!rst) dev_sr = {dev_sr[DW-2:0], 1'b0};
  end

  always @(posedge adc_sck_o) begin
    if (dev_rises == 0) dev_c1 = adc_sdi_o;
    else if (dev_rises == 1)
      // R4: sent word is {single, odd} on the first two rising edges
      check({dev_c1, adc_sdi_o} == exp_cfg[dev_idx], "R4 sdi cfg",
            32'({dev_c1, adc_sdi_o}), 32'(exp_cfg[dev_idx]));
    else if (adc_sdi_o !== 1'b0) tail_bad++;
    dev_rises++;
  end

  // port monitor
  int conv_hi = 0;
  int sck_hi = 0;
  int n_res = 0;
  logic conv_d = 1'b0;
  logic sck_d = 1'b0;

  always @(negedge clk) begin
    if (!rst) begin
      if (conv_d && !adc_conv_o)
        check(conv_hi == exp_wait, "R1 conv high time", 32'(conv_hi), 32'(exp_wait));
      if (!conv_d && adc_conv_o && dev_frame > 0)
        check(dev_rises == DW, "R2 sck edges per frame", 32'(dev_rises), 32'(DW));
      if (sck_d && !adc_sck_o)
        check(sck_hi == exp_half, "R2 sck half period", 32'(sck_hi), 32'(exp_half));
      conv_hi = adc_conv_o ? conv_hi + 1 : 0;
      sck_hi  = adc_sck_o ? sck_hi + 1 : 0;
      conv_d  = adc_conv_o;
      sck_d   = adc_sck_o;
      if (res_valid_o) begin
        check(res_data_o == word_fn(n_res), "R3 result data",
              32'(res_data_o), 32'(word_fn(n_res)));
        check(dev_rises == DW, "R2 sck edges at valid", 32'(dev_rises), 32'(DW));
        check(tail_bad == 0, "R4 sdi tail zero", 32'(tail_bad), 32'd0);
        if (n_res == 0)
          check(res_cfg_unknown_o == 1'b1, "R5 first unknown",
                32'(res_cfg_unknown_o), 32'd1);
        else
          check(res_cfg_unknown_o == 1'b0 && res_cfg_o == exp_cfg[n_res-1],
                "R5 result tag", 32'({res_cfg_unknown_o, res_cfg_o}),
                32'({1'b0, exp_cfg[n_res-1]}));
        n_res++;
      end
    end
  end

  // R6: valid lasts one clock
  logic vld_d = 1'b0;
  always @(negedge clk) begin
    if (!rst && vld_d && res_valid_o)
      check(1'b0, "R6 valid single cycle", 32'd1, 32'd0);
    vld_d = res_valid_o;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic pulse_start(input logic [1:0] c);
    @(negedge clk);
    start_i = 1'b1;
    cfg_i = c;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy_o) @(negedge clk);
  endtask

  task automatic set_timing(input int w, input int h);
    conv_wait_i = WW'(w);
    sck_half_i = VW'(h);
    exp_wait = (w == 0) ? 1 : w;
    exp_half = (h == 0) ? 1 : h;
  endtask

  initial begin
    void'($urandom(32'h5EED1234));
    repeat (4) @(negedge clk);
    // R8: reset state
    check({adc_conv_o, adc_sck_o, adc_sdi_o, res_valid_o, busy_o} == 5'b0,
          "R8 reset outputs", 32'({adc_conv_o, adc_sck_o, adc_sdi_o, res_valid_o, busy_o}), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check({adc_conv_o, adc_sck_o, busy_o} == 3'b0, "R8 after reset",
          32'({adc_conv_o, adc_sck_o, busy_o}), 32'd0);

    // directed: minimum settings
    set_timing(0, 0);
    exp_cfg[n_exp++] = 2'b10;
    pulse_start(2'b10);
    check(busy_o == 1'b1, "R9 busy after start", 32'(busy_o), 32'd1);
    wait_idle();
    check(busy_o == 1'b0 && n_res == 1, "R9 idle after frame", 32'(n_res), 32'd1);

    // directed: inputs changed mid-frame are ignored (R1, R2 latching)
    set_timing(5, 3);
    exp_cfg[n_exp++] = 2'b11;
    pulse_start(2'b11);
    conv_wait_i = WW'(9);
    sck_half_i = VW'(1);
    wait_idle();
    set_timing(5, 3);

    // random frames
    for (int i = 0; i < 10; i++) begin
      logic [1:0] c;
      c = 2'($urandom % 4);
      set_timing(int'($urandom % 9), int'($urandom % 5));
      exp_cfg[n_exp++] = c;
      pulse_start(c);
      wait_idle();
    end
    check(n_res == n_exp, "R6 one result per frame", 32'(n_res), 32'(n_exp));

    // R7: one request while busy is served afterwards
    set_timing(2, 2);
    exp_cfg[n_exp++] = 2'b00;
    pulse_start(2'b00);
    repeat (3) @(negedge clk);
    exp_cfg[n_exp++] = 2'b01;
    pulse_start(2'b01);
    wait_idle();
    check(n_res == n_exp, "R7 pending served", 32'(n_res), 32'(n_exp));

    // R7: several requests while busy merge, last configuration wins
    set_timing(1, 1);
    exp_cfg[n_exp++] = 2'b10;
    pulse_start(2'b10);
    repeat (2) @(negedge clk);
    exp_cfg[n_exp++] = 2'b11;
    pulse_start(2'b11);
    repeat (2) @(negedge clk);
    exp_cfg[n_exp-1] = 2'b01;
    pulse_start(2'b01);
    wait_idle();
    repeat (60) @(negedge clk);
    check(n_res == n_exp, "R7 merged requests", 32'(n_res), 32'(n_exp));
    check(adc_sck_o == 1'b0 && adc_conv_o == 1'b0, "R2 idle low",
          32'({adc_sck_o, adc_conv_o}), 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule